// File: doc/BRIEF.md
# Sixteen-Bit Execute Unit with Condition Flags

This unit is the arithmetic and logic stage of a small two-address RISC core. Each issued operation reads a source register value and a destination register value. In immediate forms it reads an 8-bit immediate in place of the source. It returns a 16-bit result for write-back into the destination register. The datapath does not interpret the data as signed, unsigned or Boolean. The unit also holds five condition flags, and only the add, subtract and compare families may change them.

Result and write enable are combinational from the inputs. The flag register takes its new value on the rising clock edge on which an operation is issued. There are two flag-update groups. Add and subtract rewrite carry and overflow. Compare rewrites zero, unsigned-less and signed-less. Each group leaves the other group's flags untouched. The flag register has two named states: HOLD keeps its value, and UPDATE loads it from the operation. The move from HOLD to UPDATE happens on an issued flag-writing operation, and every other cycle returns to HOLD.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `flags` becomes 0. The flag bit order is bit0 carry (C), bit1 zero (Z), bit2 signed-less (N), bit3 unsigned-less (L), bit4 overflow (F).
- R2: The opcode values are ADD=0, SUB=1, CMP=2, AND=3, OR=4, XOR=5, MOV=6, LSH=7, LUI=8. When `imm_sel` is 1, the immediate replaces `rsrc`. It is zero-extended for AND, OR and XOR and sign-extended for every other operation.
- R3: ADD gives `rdest + operand`. On issue, C takes the carry out and F takes the signed overflow. Z, N and L are kept.
- R4: SUB gives `rdest - operand`. On issue, C is set on an unsigned borrow (`rdest < operand`) and F on signed overflow. Z, N and L are kept.
- R5: CMP forms the same difference as SUB but deasserts `wr_en`. On issue, Z is set when the values are equal, L when `rdest < operand` unsigned, and N when `rdest < operand` signed. C and F are kept.
- R6: AND, OR, XOR and MOV give the bitwise result, or the operand alone for MOV, with `wr_en` high.
- R7: LSH moves `rdest` by one bit position. If the shift operand's top bit is 0 (`rsrc[15]`, or `imm8[7]` in the immediate form), the move is left; if it is 1, the move is logical right. Vacated bits are zero.
- R8: LUI gives `imm8` in bits 15:8 and zero in bits 7:0, whatever `imm_sel` is.
- R9: Logical, move, shift and LUI operations, cycles with `issue` low, and opcodes 9 to 15 leave `flags` unchanged.
- R10: `wr_en` is high only when `issue` is high and the opcode is one of the eight writing operations (not CMP and not 9 to 15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| issue | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| imm_sel | input | 1 | Use the immediate instead of `rsrc` |
| rsrc | input | 16 | Source register value |
| rdest | input | 16 | Destination register value (also a source) |
| imm8 | input | 8 | Immediate field |
| result | output | 16 | Value to write back to the destination |
| wr_en | output | 1 | Destination write enable |
| flags | output | 5 | Condition flags {F,L,N,Z,C} |

## Verification
`result` and `wr_en` are due in the same cycle as the operands. The bench drives inputs on the falling edge and samples them 1 ns later, before the next rising edge. Flags are due one rising edge after an issued operation. The bench samples them 1 ns after that edge, before it drives the next operation. It therefore sees each flag update in isolation, and the kept flags carry forward through a sequence of hand-computed vectors.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    localparam int DATA_W    = 16;
    localparam int IMM_W     = 8;
    localparam int OP_W      = 4;
    localparam int NUM_FLAGS = 5;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_L = 3;
    localparam int FL_F = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_MOV = 4'd6,
        OP_LSH = 4'd7,
        OP_LUI = 4'd8
    } alu_op_e;

    typedef enum logic {
        FS_HOLD   = 1'b0,
        FS_UPDATE = 1'b1
    } flag_state_e;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
    import alu_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [OP_W-1:0] op,
    input  logic            imm_sel,
    input  logic [DW-1:0]   rsrc,
    input  logic [IW-1:0]   imm,
    output logic [DW-1:0]   opnd,
    output logic            shift_right
);
    localparam int EXT_W = DW - IW;

    logic [DW-1:0] imm_zx;
    logic [DW-1:0] imm_sx;
    logic          logic_op;

    assign imm_zx = {{EXT_W{1'b0}}, imm};
    assign imm_sx = {{EXT_W{imm[IW-1]}}, imm};

    always_comb begin
        logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        if (!imm_sel)
            opnd = rsrc;
        else if (logic_op)
            opnd = imm_zx;
        else
            opnd = imm_sx;
        shift_right = imm_sel ? imm[IW-1] : rsrc[DW-1];
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   dst,
    input  logic [DW-1:0]   opnd,
    input  logic            shift_right,
    input  logic [IW-1:0]   imm,
    output logic [DW-1:0]   result,
    output logic            writes,
    output logic [NF-1:0]   flag_val,
    output logic [NF-1:0]   flag_mask
);
    localparam int LOW_W = DW - IW;

    logic [DW:0]   sum_x;
    logic [DW:0]   dif_x;
    logic          add_ovf;
    logic          sub_ovf;
    logic          lt_u;
    logic          lt_s;

    always_comb begin
        sum_x   = {1'b0, dst} + {1'b0, opnd};
        dif_x   = {1'b0, dst} - {1'b0, opnd};
        add_ovf = (dst[DW-1] == opnd[DW-1]) && (sum_x[DW-1] != dst[DW-1]);
        sub_ovf = (dst[DW-1] != opnd[DW-1]) && (dif_x[DW-1] != dst[DW-1]);
        lt_u    = dif_x[DW];
        lt_s    = $signed(dst) < $signed(opnd);
    end

    always_comb begin
        result    = '0;
        writes    = 1'b1;
        flag_val  = '0;
        flag_mask = '0;
        unique case (op)
            OP_ADD: begin
                result          = sum_x[DW-1:0];
                flag_val[FL_C]  = sum_x[DW];
                flag_val[FL_F]  = add_ovf;
                flag_mask[FL_C] = 1'b1;
                flag_mask[FL_F] = 1'b1;
            end
            OP_SUB: begin
                result          = dif_x[DW-1:0];
                flag_val[FL_C]  = lt_u;
                flag_val[FL_F]  = sub_ovf;
                flag_mask[FL_C] = 1'b1;
                flag_mask[FL_F] = 1'b1;
            end
            OP_CMP: begin
                result          = dif_x[DW-1:0];
                writes          = 1'b0;
                flag_val[FL_Z]  = (dif_x[DW-1:0] == '0);
                flag_val[FL_L]  = lt_u;
                flag_val[FL_N]  = lt_s;
                flag_mask[FL_Z] = 1'b1;
                flag_mask[FL_L] = 1'b1;
                flag_mask[FL_N] = 1'b1;
            end
            OP_AND: result = dst & opnd;
            OP_OR:  result = dst | opnd;
            OP_XOR: result = dst ^ opnd;
            OP_MOV: result = opnd;
            OP_LSH: result = shift_right ? {1'b0, dst[DW-1:1]} : {dst[DW-2:0], 1'b0};
            OP_LUI: result = {imm, {LOW_W{1'b0}}};
            default: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu_flag_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [NF-1:0] flag_val,
    input  logic [NF-1:0] flag_mask,
    output logic [NF-1:0] flags
);
    flag_state_e   state;
    logic [NF-1:0] flags_q;
    logic [NF-1:0] flags_d;

    always_comb begin
        state = (issue && (flag_mask != '0)) ? FS_UPDATE : FS_HOLD;
    end

    generate
        for (genvar i = 0; i < NF; i++) begin : g_bit
            always_comb begin
                unique case (state)
                    FS_UPDATE: flags_d[i] = flag_mask[i] ? flag_val[i] : flags_q[i];
                    FS_HOLD:   flags_d[i] = flags_q[i];
                    default:   flags_d[i] = flags_q[i];
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [OP_W-1:0]      opcode,
    input  logic                 imm_sel,
    input  logic [DATA_W-1:0]    rsrc,
    input  logic [DATA_W-1:0]    rdest,
    input  logic [IMM_W-1:0]     imm8,
    output logic [DATA_W-1:0]    result,
    output logic                 wr_en,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [DATA_W-1:0]    opnd;
    logic                 shift_right;
    logic                 writes;
    logic [NUM_FLAGS-1:0] flag_val;
    logic [NUM_FLAGS-1:0] flag_mask;

    alu_opnd_sel #(.DW(DATA_W), .IW(IMM_W)) u_sel (
        .op          (opcode),
        .imm_sel     (imm_sel),
        .rsrc        (rsrc),
        .imm         (imm8),
        .opnd        (opnd),
        .shift_right (shift_right)
    );

    alu_datapath #(.DW(DATA_W), .IW(IMM_W), .NF(NUM_FLAGS)) u_dp (
        .op          (opcode),
        .dst         (rdest),
        .opnd        (opnd),
        .shift_right (shift_right),
        .imm         (imm8),
        .result      (result),
        .writes      (writes),
        .flag_val    (flag_val),
        .flag_mask   (flag_mask)
    );

    alu_status_reg #(.NF(NUM_FLAGS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .flag_val  (flag_val),
        .flag_mask (flag_mask),
        .flags     (flags)
    );

    assign wr_en = issue && writes;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
    import alu_flag_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue,
    input logic [OP_W-1:0]      opcode,
    input logic                 imm_sel,
    input logic [DATA_W-1:0]    rsrc,
    input logic [DATA_W-1:0]    rdest,
    input logic [IMM_W-1:0]     imm8,
    input logic [DATA_W-1:0]    result,
    input logic                 wr_en,
    input logic [NUM_FLAGS-1:0] flags
);
    logic flag_op;
    assign flag_op = (opcode == OP_ADD) || (opcode == OP_SUB) || (opcode == OP_CMP);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flags == '0));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue || !flag_op) |=> $stable(flags));

    // R5
    cmp_keeps_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == OP_CMP) |=> ($stable(flags[FL_C]) && $stable(flags[FL_F])));

    // R5
    cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == OP_CMP && !imm_sel && rsrc == rdest) |=> flags[FL_Z]);

    // R3
    add_keeps_znl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode == OP_ADD || opcode == OP_SUB)) |=>
            ($stable(flags[FL_Z]) && $stable(flags[FL_N]) && $stable(flags[FL_L])));

    // R10
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_CMP || !issue) |-> !wr_en);

    // R8
    lui_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_LUI) |-> (result == {imm8, 8'h00}));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .opcode  (opcode),
    .imm_sel (imm_sel),
    .rsrc    (rsrc),
    .rdest   (rdest),
    .imm8    (imm8),
    .result  (result),
    .wr_en   (wr_en),
    .flags   (flags)
);

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  opcode = '0;
    logic        imm_sel = 1'b0;
    logic [15:0] rsrc = '0;
    logic [15:0] rdest = '0;
    logic [7:0]  imm8 = '0;
    logic [15:0] result;
    logic        wr_en;
    logic [4:0]  flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alu_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .imm_sel(imm_sel), .rsrc(rsrc), .rdest(rdest), .imm8(imm8),
        .result(result), .wr_en(wr_en), .flags(flags)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        im;
        logic [15:0] a;
        logic [15:0] b;
        logic [7:0]  imm;
        logic [15:0] res;
        logic        we;
        logic [4:0]  fl;
    } vec_t;

    // flags {F,L,N,Z,C}; each entry's flags are the value after that operation
    localparam vec_t TBL [18] = '{
        '{4'd0, 1'b0, 16'h0001, 16'h0002, 8'h00, 16'h0003, 1'b1, 5'h00}, // R3
        '{4'd0, 1'b0, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 1'b1, 5'h01}, // R3 carry
        '{4'd0, 1'b0, 16'h7FFF, 16'h0001, 8'h00, 16'h8000, 1'b1, 5'h10}, // R3 overflow
        '{4'd1, 1'b0, 16'h0001, 16'h0000, 8'h00, 16'hFFFF, 1'b1, 5'h01}, // R4 borrow
        '{4'd1, 1'b0, 16'h0001, 16'h8000, 8'h00, 16'h7FFF, 1'b1, 5'h10}, // R4 overflow
        '{4'd2, 1'b0, 16'h0005, 16'h0005, 8'h00, 16'h0000, 1'b0, 5'h12}, // R5 equal
        '{4'd2, 1'b0, 16'h0001, 16'hFFFF, 8'h00, 16'hFFFE, 1'b0, 5'h14}, // R5 signed less
        '{4'd2, 1'b1, 16'h0000, 16'h0001, 8'h02, 16'hFFFF, 1'b0, 5'h1C}, // R5 both less
        '{4'd3, 1'b1, 16'h0000, 16'hABCD, 8'hF0, 16'h00C0, 1'b1, 5'h1C}, // R2 R6 zero-ext
        '{4'd4, 1'b0, 16'h1200, 16'h0034, 8'h00, 16'h1234, 1'b1, 5'h1C}, // R6
        '{4'd5, 1'b1, 16'h0000, 16'hFF0F, 8'hFF, 16'hFFF0, 1'b1, 5'h1C}, // R6
        '{4'd6, 1'b0, 16'hBEEF, 16'h1111, 8'h00, 16'hBEEF, 1'b1, 5'h1C}, // R6
        '{4'd6, 1'b1, 16'h0000, 16'h1111, 8'h80, 16'hFF80, 1'b1, 5'h1C}, // R2 sign-ext
        '{4'd7, 1'b0, 16'h0001, 16'h8001, 8'h00, 16'h0002, 1'b1, 5'h1C}, // R7 left
        '{4'd7, 1'b1, 16'h0000, 16'h8001, 8'hFF, 16'h4000, 1'b1, 5'h1C}, // R7 right
        '{4'd8, 1'b0, 16'hFFFF, 16'h1234, 8'hA5, 16'hA500, 1'b1, 5'h1C}, // R8
        '{4'd0, 1'b1, 16'h0000, 16'h0001, 8'hFF, 16'h0000, 1'b1, 5'h0D}, // R3 imm
        '{4'd1, 1'b1, 16'h0000, 16'h0003, 8'h01, 16'h0002, 1'b1, 5'h0C}  // R4 imm
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic iss, input logic [3:0] op, input logic im,
                         input logic [15:0] a, input logic [15:0] b, input logic [7:0] im8);
        @(negedge clk);
        issue = iss; opcode = op; imm_sel = im; rsrc = a; rdest = b; imm8 = im8;
        #1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "flags after reset", {11'd0, flags}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 18; i++) begin
            apply(1'b1, TBL[i].op, TBL[i].im, TBL[i].a, TBL[i].b, TBL[i].imm);
            check("R2-R8 vec", $sformatf("result %0d", i), result, TBL[i].res);
            check("R10", $sformatf("wr_en %0d", i), {15'd0, wr_en}, {15'd0, TBL[i].we});
            @(posedge clk);
            #1;
            check("R3 R4 R5 R9", $sformatf("flags %0d", i), {11'd0, flags}, {11'd0, TBL[i].fl});
        end

        // R9: no issue, overflowing add presented: flags kept, no write
        apply(1'b0, 4'd0, 1'b0, 16'h7FFF, 16'h7FFF, 8'h00);
        check("R10", "wr_en idle", {15'd0, wr_en}, 16'h0000);
        @(posedge clk); #1;
        check("R9", "flags idle", {11'd0, flags}, 16'h000C);

        // R9 R10: undefined opcode
        apply(1'b1, 4'd11, 1'b0, 16'hFFFF, 16'hFFFF, 8'h00);
        check("R10", "wr_en undefined op", {15'd0, wr_en}, 16'h0000);
        @(posedge clk); #1;
        check("R9", "flags undefined op", {11'd0, flags}, 16'h000C);

        // R8: LUI in immediate form is the same
        apply(1'b1, 4'd8, 1'b1, 16'h0000, 16'hFFFF, 8'h01);
        check("R8", "lui imm form", result, 16'h0100);

        // R7: shift right of zero-top value, register direction bit 1
        apply(1'b1, 4'd7, 1'b0, 16'h8000, 16'h0001, 8'h00);
        check("R7", "shift right out", result, 16'h0000);

        // R1: reset mid-run clears flags
        apply(1'b0, 4'd0, 1'b0, 16'h0, 16'h0, 8'h00);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", "flags mid-run reset", {11'd0, flags}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule